// File: doc/BRIEF.md
# Slave Port Parking Arbiter

This block decides which of six bus masters owns one slave port of a multi-layer interconnect. Every slave port has its own copy. Each cycle it looks at the masters' request lines and at the slave's transfer status. It holds a registered one-hot grant and reports which requesting master is actually connected this cycle. Ownership moves only at a transfer boundary, which is a cycle where the slave is ready and no locked sequence is running. Several requesters at a boundary are served in round-robin order.

When a boundary passes with no request pending, the port parks according to a programmable policy:
- It can drop every grant.
- It can stay with the master that won most recently.
- It can move to a programmed master.

The parked master is already granted, so when it requests it is connected in the same cycle. Any other master first has to win a boundary and is connected one cycle later. A configuration write is held aside. It only replaces the active policy at the next boundary that finds no request.

Top module: `slave_park_arb`

## Requirements
- R1: While reset is held and after it is released, `grant` and `connected` are zero. The active policy is no-parking, and no previous winner is remembered.
- R2: `grant` is at most one-hot. It keeps its value through any cycle where `slv_ready` is low.
- R3: `connected` flags a master only while that master both requests and holds the grant. A parked master that requests is connected in that same cycle. A master that wins a boundary is connected from the following cycle.
- R4: At a boundary with requests pending, the winner is the first requester found by scanning upward from the index after the last winner, wrapping from 5 back to 0. Before any master has won, the scan starts at master 0.
- R5: Policy value 2'b00 (no parking): an idle boundary clears `grant` to zero.
- R6: Policy value 2'b01 (last winner): an idle boundary leaves the grant on the most recent winner. If no master has won yet, the grant is zero.
- R7: Policy value 2'b10 (fixed): an idle boundary moves the grant to the master numbered `cfg_master` (bit `cfg_master` of `grant`). Traffic by other masters never changes this choice.
- R8: Policy value 2'b11 behaves exactly like 2'b00.
- R9: Under the fixed policy, a `cfg_master` value of 6 or more behaves like no parking.
- R10: A write (`cfg_wr` high) is captured at that clock edge. It first takes effect at the first idle boundary in a later cycle, and that boundary already parks by the new value. Boundaries that carry requests leave it pending. A later write replaces a pending one.
- R11: While `xfer_locked` is high, `grant` is held even when `slv_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_req | input | 6 | Request line of each master |
| slv_ready | input | 1 | Slave completes the current transfer this cycle |
| xfer_locked | input | 1 | A locked sequence is in progress; no ownership change |
| cfg_wr | input | 1 | Write strobe for the parking configuration |
| cfg_policy | input | 2 | Parking policy: 00 none, 01 last winner, 10 fixed, 11 none |
| cfg_master | input | 4 | Fixed master index, used under policy 10 |
| grant | output | 6 | Registered one-hot owner of the slave port |
| connected | output | 6 | Master requesting and owning the port this cycle |

## Verification
Two pairs of events can land in the same cycle. The first pair is a configuration write and an idle boundary. The bench writes at an idle boundary and checks that this boundary still parks by the old policy, and that the new policy is used at the next one. The second pair is a pending configuration change and a boundary that carries requests. The bench checks that arbitration proceeds and that the new parking target appears only at the first request-free boundary that follows. Round-robin rotation, locked holds and the zero-latency parked master are judged cycle by cycle against hand-computed expected grants, which a scoreboard queue compares with the outputs.

// File: rtl/spa_pkg.sv
package spa_pkg;
  localparam int POL_W = 2;
  localparam int MIDX_W = 4;

  typedef enum logic [POL_W-1:0] {
    POL_NONE  = 2'b00,
    POL_LAST  = 2'b01,
    POL_FIXED = 2'b10,
    POL_ALT   = 2'b11
  } park_pol_e;

  typedef struct packed {
    logic [POL_W-1:0]  pol;
    logic [MIDX_W-1:0] midx;
  } park_cfg_t;
endpackage

// File: rtl/spa_cfg_shadow.sv
module spa_cfg_shadow
  import spa_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  park_cfg_t wr_cfg,
  input  logic      apply,
  output park_cfg_t eff_cfg,
  output park_cfg_t act_cfg,
  output logic      pend_v
);
  park_cfg_t act_q, pend_q;
  logic      pend_q_v;

  // configuration the next idle boundary will use
  assign eff_cfg = pend_q_v ? pend_q : act_q;
  assign act_cfg = act_q;
  assign pend_v  = pend_q_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= '{pol: POL_NONE, midx: '0};
      pend_q   <= '{pol: POL_NONE, midx: '0};
      pend_q_v <= 1'b0;
    end else begin
      if (apply) begin
        act_q    <= eff_cfg;
        pend_q_v <= 1'b0;
      end
      if (wr) begin
        pend_q   <= wr_cfg;
        pend_q_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spa_rr_pick.sv
module spa_rr_pick #(
  parameter int N  = 6,
  parameter int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] last_idx,
  input  logic          last_v,
  output logic          any,
  output logic [LW-1:0] win
);
  int unsigned start;

  always_comb begin
    if (!last_v || int'(last_idx) >= N - 1) start = 0;
    else                                    start = int'(last_idx) + 1;
  end

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int k = 0; k < N; k++) begin
      int unsigned c;
      c = (start + k) % N;
      if (!any && req[c]) begin
        any = 1'b1;
        win = LW'(c);
      end
    end
  end
endmodule

// File: rtl/spa_park_sel.sv
module spa_park_sel
  import spa_pkg::*;
#(
  parameter int N  = 6,
  parameter int LW = (N > 1) ? $clog2(N) : 1
) (
  input  park_cfg_t     cfg,
  input  logic [LW-1:0] last_idx,
  input  logic          last_v,
  output logic [N-1:0]  park_vec
);
  logic          tgt_v;
  logic [MIDX_W-1:0] tgt;

  always_comb begin
    tgt_v = 1'b0;
    tgt   = '0;
    unique case (park_pol_e'(cfg.pol))
      POL_LAST: begin
        tgt_v = last_v;
        tgt   = MIDX_W'(last_idx);
      end
      POL_FIXED: begin
        tgt_v = (int'(cfg.midx) < N);
        tgt   = cfg.midx;
      end
      POL_NONE, POL_ALT: begin
        tgt_v = 1'b0;
        tgt   = '0;
      end
      default: begin
        tgt_v = 1'b0;
        tgt   = '0;
      end
    endcase
  end

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign park_vec[g] = tgt_v && (int'(tgt) == g);
  end
endmodule

// File: rtl/slave_park_arb.sv
module slave_park_arb
  import spa_pkg::*;
#(
  parameter int NUM_MASTERS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] mst_req,
  input  logic                   slv_ready,
  input  logic                   xfer_locked,
  input  logic                   cfg_wr,
  input  logic [POL_W-1:0]       cfg_policy,
  input  logic [MIDX_W-1:0]      cfg_master,
  output logic [NUM_MASTERS-1:0] grant,
  output logic [NUM_MASTERS-1:0] connected
);
  localparam int LW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  logic [NUM_MASTERS-1:0] grant_q, grant_d, park_vec;
  logic [LW-1:0]          last_q, win;
  logic                   last_v_q, any_req, boundary, idle_bnd;
  park_cfg_t              eff_cfg, act_cfg;
  logic                   pend_v;
  logic [POL_W-1:0]       act_pol;
  logic [MIDX_W-1:0]      act_idx;

  assign boundary = slv_ready && !xfer_locked;
  assign idle_bnd = boundary && !any_req;
  assign act_pol  = act_cfg.pol;
  assign act_idx  = act_cfg.midx;

  spa_cfg_shadow u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .wr_cfg  ('{pol: cfg_policy, midx: cfg_master}),
    .apply   (idle_bnd),
    .eff_cfg (eff_cfg),
    .act_cfg (act_cfg),
    .pend_v  (pend_v)
  );

  spa_rr_pick #(.N(NUM_MASTERS), .LW(LW)) u_pick (
    .req      (mst_req),
    .last_idx (last_q),
    .last_v   (last_v_q),
    .any      (any_req),
    .win      (win)
  );

  spa_park_sel #(.N(NUM_MASTERS), .LW(LW)) u_park (
    .cfg      (eff_cfg),
    .last_idx (last_q),
    .last_v   (last_v_q),
    .park_vec (park_vec)
  );

  always_comb begin
    grant_d = grant_q;
    if (boundary) begin
      if (any_req) grant_d = NUM_MASTERS'(1) << win;
      else         grant_d = park_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q  <= '0;
      last_q   <= '0;
      last_v_q <= 1'b0;
    end else begin
      grant_q <= grant_d;
      if (boundary && any_req) begin
        last_q   <= win;
        last_v_q <= 1'b1;
      end
    end
  end

  assign grant     = grant_q;
  assign connected = grant_q & mst_req;
endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
  parameter int NM = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] mst_req,
  input logic          slv_ready,
  input logic          xfer_locked,
  input logic [NM-1:0] grant,
  input logic [NM-1:0] connected,
  input logic [1:0]    act_pol,
  input logic [3:0]    act_idx,
  input logic          pend_v
);
  logic bnd;
  assign bnd = slv_ready && !xfer_locked;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_ready |=> $stable(grant)); // R2

  AST_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_locked |=> $stable(grant)); // R11

  AST_CONN_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (connected != '0) |-> ((connected & ~grant) == '0)); // R3

  AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && mst_req != '0) |=> ((grant & $past(mst_req)) != '0)); // R4

  AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && mst_req == '0 && !pend_v && (act_pol == 2'b00 || act_pol == 2'b11))
      |=> grant == '0); // R5

  AST_FIXED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && mst_req == '0 && !pend_v && act_pol == 2'b10 && int'(act_idx) < NM)
      |=> grant[$past(act_idx)]); // R7

  AST_FIXED_BAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && mst_req == '0 && !pend_v && act_pol == 2'b10 && int'(act_idx) >= NM)
      |=> grant == '0); // R9
endmodule

bind slave_park_arb spa_checker #(.NM(NUM_MASTERS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mst_req     (mst_req),
  .slv_ready   (slv_ready),
  .xfer_locked (xfer_locked),
  .grant       (grant),
  .connected   (connected),
  .act_pol     (act_pol),
  .act_idx     (act_idx),
  .pend_v      (pend_v)
);

// File: tb/tb_slave_park_arb.sv
`timescale 1ns/1ps
module tb_slave_park_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] mst_req = '0;
  logic       slv_ready = 1'b0;
  logic       xfer_locked = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_policy = '0;
  logic [3:0] cfg_master = '0;
  logic [5:0] grant, connected;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  slave_park_arb dut (
    .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .slv_ready(slv_ready),
    .xfer_locked(xfer_locked), .cfg_wr(cfg_wr), .cfg_policy(cfg_policy),
    .cfg_master(cfg_master), .grant(grant), .connected(connected)
  );

  // driver: apply one cycle of stimulus, queue the outputs expected for it
  task automatic cyc(input logic [5:0] r, input bit rdy, input bit lck,
                     input bit wr, input logic [1:0] pol, input logic [3:0] idx,
                     input logic [5:0] eg, input string tag);
    @(negedge clk);
    mst_req     = r;
    slv_ready   = rdy;
    xfer_locked = lck;
    cfg_wr      = wr;
    if (wr) begin
      cfg_policy = pol;
      cfg_master = idx;
    end
    exp_q.push_back({eg, eg & r});
    tag_q.push_back(tag);
  endtask

  // monitor: compare queued expectations after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() != 0) begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (grant !== e[11:6] || connected !== e[5:0]) begin
          failures++;
          $display("FAIL %s grant=%b connected=%b expected grant=%b connected=%b",
                   t, grant, connected, e[11:6], e[5:0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mst_req = 6'b001010;
    slv_ready = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== 6'b0 || connected !== 6'b0) begin
      failures++;
      $display("FAIL R1 in reset grant=%b connected=%b expected 000000/000000", grant, connected);
    end
    mst_req = '0;
    rst_n = 1'b1;
    //     req        rdy lck wr pol  idx    expected grant
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000000, "R1 after reset");
    cyc(6'b000100, 1, 0, 0, 2'b00, 4'd0, 6'b000000, "R3 non-parked not yet connected");
    cyc(6'b000100, 0, 0, 0, 2'b00, 4'd0, 6'b000100, "R3 connected one cycle later");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000100, "R2 held while not ready");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000000, "R5 no parking clears grant");
    cyc(6'b100001, 1, 0, 0, 2'b00, 4'd0, 6'b000000, "R5 idle stays clear");
    cyc(6'b100001, 1, 0, 0, 2'b00, 4'd0, 6'b100000, "R4 scan after master 2 picks 5");
    cyc(6'b100001, 1, 0, 0, 2'b00, 4'd0, 6'b000001, "R4 wrap picks master 0");
    cyc(6'b000001, 1, 1, 0, 2'b00, 4'd0, 6'b100000, "R4 rotation back to master 5");
    cyc(6'b000001, 1, 0, 0, 2'b00, 4'd0, 6'b100000, "R11 locked hold");
    cyc(6'b000000, 1, 0, 1, 2'b01, 4'd0, 6'b000001, "R10 write at idle boundary");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000000, "R10 old policy used at write cycle");
    cyc(6'b000001, 1, 0, 0, 2'b00, 4'd0, 6'b000001, "R6 parked on last winner zero latency");
    cyc(6'b000010, 1, 0, 0, 2'b00, 4'd0, 6'b000001, "R6 other master waits");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000010, "R6 new winner");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000010, "R6 parked on last winner");
    cyc(6'b000000, 1, 0, 1, 2'b10, 4'd3, 6'b000010, "R10 write fixed 3");
    cyc(6'b000000, 0, 0, 0, 2'b00, 4'd0, 6'b000010, "R10 not applied without boundary");
    cyc(6'b000001, 1, 0, 0, 2'b00, 4'd0, 6'b000010, "R10 busy boundary keeps pending");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000001, "R4 winner master 0");
    cyc(6'b100000, 1, 0, 0, 2'b00, 4'd0, 6'b001000, "R7 parked on fixed master 3");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b100000, "R7 traffic winner");
    cyc(6'b001000, 0, 0, 0, 2'b00, 4'd0, 6'b001000, "R7 fixed master back after traffic");
    cyc(6'b000000, 1, 0, 1, 2'b10, 4'd7, 6'b001000, "R7 write of index 7 pending");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b001000, "R7 old fixed master kept");
    cyc(6'b000000, 1, 0, 1, 2'b11, 4'd2, 6'b000000, "R9 index 7 means no parking");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000000, "R8 policy 11 applied");
    cyc(6'b000100, 1, 0, 0, 2'b00, 4'd0, 6'b000000, "R8 idle grant zero");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000100, "R4 scan after 5 picks 2");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000000, "R8 policy 11 clears like none");
    cyc(6'b000000, 1, 0, 1, 2'b10, 4'd5, 6'b000000, "R7 write fixed 5");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000000, "R10 fixed 5 not yet active");
    cyc(6'b000000, 1, 0, 1, 2'b10, 4'd6, 6'b100000, "R7 parked on master 5");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b100000, "R9 index 6 pending");
    cyc(6'b000000, 1, 0, 0, 2'b00, 4'd0, 6'b000000, "R9 index 6 means no parking");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule